// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

A 16-bit up-counter with three operating modes: capture, auto-reload and baud-clock generation. It counts either a qualified tick from the surrounding clock divider (timer mode) or falling edges on an external count pin (counter mode). A second external pin acts as a trigger. Depending on the mode, a falling edge on it either snapshots the counter or forces the counter back to its reload value.

Software accesses the counter halves, the reload/capture pair and an 8-bit control register through a byte-wide register port with single-cycle writes and combinational reads. The block raises an overflow flag and an external-event flag, and drives an interrupt request when either flag is set and the request is enabled. In baud mode the block stops reporting overflows through the flag. Instead, each overflow produces a one-cycle pulse that a serial port can use as its bit clock.

Top module: `cap_reload_timer`

## Requirements
- R1: After the asynchronous reset every register reads 0, and `ovf_flag_o`, `ext_flag_o`, `irq_o` and `baud_pulse_o` are 0.
- R2: Register addresses are 0 for control, 1 and 2 for the counter low and high bytes, and 3 and 4 for the reload/capture low and high bytes. A write stores the byte and a read returns it. Control bit positions are: 7 overflow flag, 6 external flag, 5 receive-clock select, 4 transmit-clock select, 3 external enable, 2 run, 1 counter select (1 = count pin edges), 0 capture select (1 = capture mode). With run at 1 and counter select at 0, the counter advances by one on each clock with `tick_i` high. With run at 0 it holds.
- R3: In counter mode the counter advances once for each falling edge on `cnt_pin_i`. An edge is seen when the pin reads 1 at one `tick_i` sample and 0 at the next. Ticks with no edge do not advance it.
- R4: In capture mode (both clock selects 0, capture select 1), an overflow from FFFFh wraps the counter to 0000h and sets the overflow flag. With external enable at 1, a trigger falling edge copies the counter into the reload/capture pair and sets the external flag, and the counter is left unchanged.
- R5: In auto-reload mode (both clock selects 0, capture select 0), an overflow loads the counter from the reload pair and sets the overflow flag.
- R6: In auto-reload mode with external enable at 1, a trigger falling edge loads the counter from the reload pair and sets the external flag.
- R7: With external enable at 0, trigger edges change neither the counter nor the external flag.
- R8: With either clock select at 1 (baud mode), every overflow reloads the counter and drives `baud_pulse_o` high for exactly one clock. The overflow flag is not set, and trigger edges are ignored.
- R9: Both flags stay set until software writes the control register. Hardware never clears them.
- R10: `irq_o` is high exactly when `irq_en_i` is high and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count qualifier and pin-sampling strobe |
| cnt_pin_i | input | 1 | External count pin |
| trig_pin_i | input | 1 | External capture/reload trigger pin |
| irq_en_i | input | 1 | Interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External-event flag |
| irq_o | output | 1 | Interrupt request |
| baud_pulse_o | output | 1 | One-cycle pulse on each baud-mode overflow |

## Verification
The properties assume that software writes only the control register to clear a flag. They also assume that a counter held in place is not being reloaded by a trigger, which is why the hold property is conditioned on the external enable being 0. The stimulus drives every pin and strobe on the falling clock edge. It holds `tick_i` high only across the edges where a count or a pin sample is intended. It writes the control register only while `tick_i` is low, so software writes never coincide with counting or trigger detection.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_RLD_LO = 3'd3,
    A_RLD_HI = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic ovf;
    logic ext;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic cnt_mode;
    logic cap_mode;
  } ctrl_t;

  typedef enum logic [1:0] {
    M_CAPTURE = 2'd0,
    M_RELOAD  = 2'd1,
    M_BAUD    = 2'd2
  } mode_e;
endpackage

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic pin_i,
  output logic fall_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= 1'b0;
    else if (sample_i) last_q <= pin_i;
  end

  // previous sample 1, current sample 0
  assign fall_o = sample_i & last_q & ~pin_i;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  tmr_pkg::mode_e       mode_i,
  input  logic                 inc_i,
  input  logic                 trig_i,
  input  logic [1:0]           cnt_we_i,
  input  logic [1:0]           rld_we_i,
  input  logic [CNT_W/2-1:0]   wdata_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]     rld_o,
  output logic                 wrap_o,
  output logic                 baud_o
);
  import tmr_pkg::*;
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic             baud_q;

  assign wrap_o = inc_i & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    if (inc_i) begin
      if (wrap_o) cnt_d = (mode_i == M_CAPTURE) ? '0 : rld_q;
      else        cnt_d = cnt_q + 1'b1;
    end
    if (trig_i) begin
      if (mode_i == M_RELOAD)  cnt_d = rld_q;
      if (mode_i == M_CAPTURE) rld_d = cnt_q;
    end
    for (int h = 0; h < 2; h++) begin
      if (cnt_we_i[h]) cnt_d[h*HALF +: HALF] = wdata_i;
      if (rld_we_i[h]) rld_d[h*HALF +: HALF] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      baud_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      baud_q <= wrap_o & (mode_i == M_BAUD);
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign baud_o = baud_q;
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
  parameter int CNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                cnt_pin_i,
  input  logic                trig_pin_i,
  input  logic                irq_en_i,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [CNT_W/2-1:0]  reg_wdata_i,
  output logic [CNT_W/2-1:0]  reg_rdata_o,
  output logic                ovf_flag_o,
  output logic                ext_flag_o,
  output logic                irq_o,
  output logic                baud_pulse_o
);
  import tmr_pkg::*;
  localparam int HALF = CNT_W / 2;
  localparam int NPIN = 2;

  ctrl_t            ctrl_q, ctrl_d;
  mode_e            mode;
  logic [NPIN-1:0]  pins, falls;
  logic             cnt_fall, trig_fall, inc, ext_evt, wrap;
  logic [1:0]       cnt_we, rld_we;
  logic [CNT_W-1:0] cnt_w, rld_w;

  assign pins = {trig_pin_i, cnt_pin_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_det
    tmr_fall_det u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sample_i(tick_i),
      .pin_i   (pins[p]),
      .fall_o  (falls[p])
    );
  end

  assign cnt_fall  = falls[0];
  assign trig_fall = falls[1];

  always_comb begin
    if (ctrl_q.rx_sel || ctrl_q.tx_sel) mode = M_BAUD;
    else if (ctrl_q.cap_mode)           mode = M_CAPTURE;
    else                                mode = M_RELOAD;
  end

  assign inc     = ctrl_q.run & (ctrl_q.cnt_mode ? cnt_fall : tick_i);
  assign ext_evt = trig_fall & ctrl_q.ext_en & (mode != M_BAUD);

  assign cnt_we = {reg_we_i && reg_addr_i == A_CNT_HI, reg_we_i && reg_addr_i == A_CNT_LO};
  assign rld_we = {reg_we_i && reg_addr_i == A_RLD_HI, reg_we_i && reg_addr_i == A_RLD_LO};

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .inc_i   (inc),
    .trig_i  (ext_evt),
    .cnt_we_i(cnt_we),
    .rld_we_i(rld_we),
    .wdata_i (reg_wdata_i),
    .cnt_o   (cnt_w),
    .rld_o   (rld_w),
    .wrap_o  (wrap),
    .baud_o  (baud_pulse_o)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we_i && reg_addr_i == A_CTRL) ctrl_d = ctrl_t'(reg_wdata_i);
    // hardware set wins over a same-cycle software write
    if (wrap && mode != M_BAUD) ctrl_d.ovf = 1'b1;
    if (ext_evt)                ctrl_d.ext = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:   reg_rdata_o = ctrl_q;
      A_CNT_LO: reg_rdata_o = cnt_w[HALF-1:0];
      A_CNT_HI: reg_rdata_o = cnt_w[CNT_W-1:HALF];
      A_RLD_LO: reg_rdata_o = rld_w[HALF-1:0];
      A_RLD_HI: reg_rdata_o = rld_w[CNT_W-1:HALF];
      default:  reg_rdata_o = '0;
    endcase
  end

  assign ovf_flag_o = ctrl_q.ovf;
  assign ext_flag_o = ctrl_q.ext;
  assign irq_o      = irq_en_i & (ctrl_q.ovf | ctrl_q.ext);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic             ovf_flag_o,
  input logic             ext_flag_o,
  input logic             baud_pulse_o,
  input tmr_pkg::ctrl_t   ctrl,
  input logic [CNT_W-1:0] cnt
);
  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl.rx_sel || ctrl.tx_sel) && !ovf_flag_o && !reg_we_i) |=> !ovf_flag_o);

  // R9
  ovf_sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_flag_o) |-> $past(reg_we_i && reg_addr_i == 3'd0));

  // R9
  ext_sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_flag_o) |-> $past(reg_we_i && reg_addr_i == 3'd0));

  // R7
  trig_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.ext_en && !reg_we_i) |=> !$rose(ext_flag_o));

  // R2
  hold_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.run && !ctrl.ext_en && !reg_we_i) |=> $stable(cnt));

  // R8
  baud_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_pulse_o |-> $past(ctrl.rx_sel || ctrl.tx_sel));
endmodule

bind cap_reload_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .ovf_flag_o  (ovf_flag_o),
  .ext_flag_o  (ext_flag_o),
  .baud_pulse_o(baud_pulse_o),
  .ctrl        (ctrl_q),
  .cnt         (cnt_w)
);

// File: tb/cap_reload_timer_test.sv
module cap_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0, irq_en = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ovf, ext, irq, baud;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cap_reload_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_pin_i(cnt_pin),
    .trig_pin_i(trig_pin), .irq_en_i(irq_en), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ovf_flag_o(ovf), .ext_flag_o(ext), .irq_o(irq), .baud_pulse_o(baud)
  );

  // {addr, write data, expected readback}
  localparam logic [18:0] VEC [6] = '{
    {3'd3, 8'h34, 8'h34}, {3'd4, 8'h12, 8'h12}, {3'd1, 8'hFE, 8'hFE},
    {3'd2, 8'hFF, 8'hFF}, {3'd0, 8'h0B, 8'h0B}, {3'd0, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] d);
    logic [7:0] l, h;
    rd(lo, l); rd(lo + 3'd1, h); d = {h, l};
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] d);
    wr(lo, d[7:0]); wr(lo + 3'd1, d[15:8]);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse(input logic on_trig);
    @(negedge clk); tick = 1'b1;
    if (on_trig) trig_pin = 1'b1; else cnt_pin = 1'b1;
    @(negedge clk);
    trig_pin = 1'b0; cnt_pin = 1'b0;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    int          np;

    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b); check("R1 reg", {8'h0, b}, 16'h0);
    end
    check("R1 outputs", {12'h0, ovf, ext, irq, baud}, 16'h0);
    rst_n = 1'b1;

    // R2 register access table
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], b);
      check("R2 readback", {8'h0, b}, {8'h0, VEC[i][7:0]});
    end

    // R2/R5 timer mode, auto-reload
    wr(3'd0, 8'h04);
    run_ticks(1);
    rd16(3'd1, w); check("R2 tick count", w, 16'hFFFF);
    rd(3'd0, b);   check("R5 no flag before wrap", {8'h0, b}, 16'h04);
    run_ticks(1);
    rd16(3'd1, w); check("R5 reload on wrap", w, 16'h1234);
    rd(3'd0, b);   check("R5 ovf flag", {8'h0, b}, 16'h84);
    check("R10 irq masked", {15'h0, irq}, 16'h0);
    run_ticks(3);
    rd16(3'd1, w); check("R2 count after wrap", w, 16'h1237);
    rd(3'd0, b);   check("R9 flag persists", {8'h0, b}, 16'h84);
    irq_en = 1'b1; #1;
    check("R10 irq raised", {15'h0, irq}, 16'h1);
    wr(3'd0, 8'h04); #1;
    check("R9 sw clear", {15'h0, ovf}, 16'h0);
    check("R10 irq drops", {15'h0, irq}, 16'h0);
    wr(3'd0, 8'h00);
    run_ticks(5);
    rd16(3'd1, w); check("R2 stopped hold", w, 16'h1237);

    // R3 counter mode
    wr(3'd0, 8'h06);
    for (int k = 0; k < 3; k++) pulse(1'b0);
    run_ticks(4);
    rd16(3'd1, w); check("R3 edge count", w, 16'h123A);

    // R7 trigger ignored
    wr(3'd0, 8'h00);
    pulse(1'b1);
    rd16(3'd1, w); check("R7 cnt untouched", w, 16'h123A);
    check("R7 ext flag", {15'h0, ext}, 16'h0);

    // R6 reload by trigger
    wr16(3'd1, 16'h5555);
    wr(3'd0, 8'h08);
    pulse(1'b1);
    rd16(3'd1, w); check("R6 trigger reload", w, 16'h1234);
    rd(3'd0, b);   check("R6 ext flag", {8'h0, b}, 16'h48);
    check("R10 irq on ext", {15'h0, irq}, 16'h1);
    wr(3'd0, 8'h00);

    // R4 capture
    wr16(3'd1, 16'hABCD);
    wr(3'd0, 8'h09);
    pulse(1'b1);
    rd16(3'd3, w); check("R4 captured", w, 16'hABCD);
    rd16(3'd1, w); check("R4 cnt kept", w, 16'hABCD);
    rd(3'd0, b);   check("R4 ext flag", {8'h0, b}, 16'h49);
    wr(3'd0, 8'h00);
    wr16(3'd1, 16'hFFFF);
    wr(3'd0, 8'h05);
    run_ticks(1);
    rd16(3'd1, w); check("R4 wrap to zero", w, 16'h0000);
    rd(3'd0, b);   check("R4 ovf flag", {8'h0, b}, 16'h85);
    wr(3'd0, 8'h00);

    // R8 baud mode, receive select
    wr16(3'd3, 16'hFFFD);
    wr16(3'd1, 16'hFFFD);
    wr(3'd0, 8'h24);
    np = 0;
    @(negedge clk); tick = 1'b1;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      if (baud) np++;
    end
    tick = 1'b0;
    check("R8 pulse count", 16'(np), 16'd3);
    @(negedge clk);
    check("R8 pulse width", {15'h0, baud}, 16'h0);
    rd16(3'd1, w); check("R8 reload", w, 16'hFFFD);
    rd(3'd0, b);   check("R8 no ovf flag", {8'h0, b}, 16'h24);

    // R8 transmit select
    wr(3'd0, 8'h14);
    np = 0;
    @(negedge clk); tick = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (baud) np++;
    end
    tick = 1'b0;
    check("R8 tx pulse", 16'(np), 16'd1);
    rd(3'd0, b);   check("R8 tx no flag", {8'h0, b}, 16'h14);

    // R8 trigger ignored in baud mode
    wr(3'd0, 8'h28);
    pulse(1'b1);
    rd(3'd0, b);   check("R8 trig ignored", {8'h0, b}, 16'h28);
    rd16(3'd1, w); check("R8 cnt kept", w, 16'hFFFD);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule